// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Open-Drain Option

This block controls six general-purpose pins through a small register bus. Software sets each pin's direction, the value it drives and whether it drives both levels or only pulls low. For every pin the block produces an output value and an output enable. The enable is meant for a pad or a bench model that has a pull-up, so a pin whose enable is low floats high.

A read-only pin-state location shows the level of each pin. For pins configured as outputs it returns the latched output value. For input pins it returns the pad level after a two-stage synchroniser. The block has an asynchronous reset and two standby levels. Hardware standby clears the configuration and releases every pin. Software standby freezes the configuration and the pin-state view.

The bus uses a 2-bit address with write and read strobes. Read data is returned combinationally in the same cycle. Register bits 5 down to 0 map to pins 5 down to 0.

Top module: `gpio6_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, the direction, output-value and open-drain registers hold 0. No output enable is active, and reads of addresses 0, 1 and 2 return 8'h00.
- R2: Address 0 is the direction register (1 = output), address 1 is the output-value register and address 2 is the open-drain register. A write stores `bus_wdata[5:0]`, and a read returns the stored bits in positions 5:0. Bits 7:6 always read 0, and writes to bits 7:6 have no effect.
- R3: A write to address 3 (pin state) changes no register and no pin output.
- R4: A read of address 3 returns, in bit i, the output-value bit when direction bit i is 1. When direction bit i is 0, it returns `pad_in[i]` as sampled by a two-flop synchroniser. A change on `pad_in` first appears in the read after the second rising edge that follows it.
- R5: A pin with direction 1 and open-drain 0 has `pad_oe` = 1 and `pad_out` equal to its output-value bit.
- R6: A pin with direction 1 and open-drain 1 has `pad_out` = 0 and `pad_oe` equal to the inverse of its output-value bit, so a 1 releases the pin.
- R7: A pin with direction 0 never has `pad_oe` active.
- R8: While `hw_stby` is high, every `pad_oe` is 0 in the same cycle. Each rising edge clears the direction, output-value and open-drain registers, writes are ignored, and the synchroniser keeps sampling the pads.
- R9: While `sw_stby` is high and `hw_stby` is low, writes are ignored and the three registers keep their values. The synchroniser also holds, so the pin-state read value stays unchanged.
- R10: `bus_rdata` is 8'h00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby level: clears the registers and releases all pins |
| sw_stby | input | 1 | Software standby level: freezes the registers and the pin-state view |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 6 | Pad levels seen from outside |
| pad_out | output | 6 | Value driven on each pin when enabled |
| pad_oe | output | 6 | Per-pin drive enable |

## Verification
The bound checker watches these rules on every cycle:
- the drive rules: no enable on an input pin, no high drive on an open-drain pin, and no enable at all during hardware standby;
- clearing of the registers after a hardware-standby edge and their freezing under software standby;
- zero read data when idle and zero reserved bits.

Only the bench scenarios can show the two-edge delay of a pad change into the pin-state read. They also show that address 3 ignores writes, that the synchroniser is frozen during software standby, and that register contents read back correctly. A behavioural reference model is compared with the outputs on every cycle.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
    localparam int PIN_W  = 6;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int RSV_W  = REG_W - PIN_W;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DIR = 2'd0,
        ADDR_VAL = 2'd1,
        ADDR_ODC = 2'd2,
        ADDR_PIN = 2'd3
    } addr_e;

    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] val;
        logic [PIN_W-1:0] odc;
    } port_regs_t;
endpackage

// File: rtl/gpio6_regs.sv
module gpio6_regs
    import gpio6_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output port_regs_t        regs_q
);
    port_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (hw_stby) begin
            regs_d = '0;
        end else if (!sw_stby && wr_en) begin
            case (addr_e'(addr))
                ADDR_DIR: regs_d.dir = wdata[PIN_W-1:0];
                ADDR_VAL: regs_d.val = wdata[PIN_W-1:0];
                ADDR_ODC: regs_d.odc = wdata[PIN_W-1:0];
                default:  regs_d = regs_q;   // pin-state location is read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) stg_d[i] = stg_q[i];
        if (!hold) begin
            stg_d[0] = d;
            for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio6_drive.sv
module gpio6_drive #(
    parameter int W = 6
) (
    input  logic         hw_stby,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] val,
    input  logic [W-1:0] odc,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // open-drain pins never present a high level; a 1 only releases the pin
        assign pad_out[i] = odc[i] ? 1'b0 : val[i];
        assign pad_oe[i]  = !hw_stby && dir[i] && (!odc[i] || !val[i]);
    end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe
);
    port_regs_t       regs_q;
    logic [PIN_W-1:0] pad_sync;
    logic [PIN_W-1:0] rd_val;
    logic             sync_hold;

    assign sync_hold = sw_stby && !hw_stby;

    gpio6_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .regs_q  (regs_q)
    );

    gpio6_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (sync_hold),
        .d     (pad_in),
        .q     (pad_sync)
    );

    gpio6_drive #(.W(PIN_W)) u_drive (
        .hw_stby (hw_stby),
        .dir     (regs_q.dir),
        .val     (regs_q.val),
        .odc     (regs_q.odc),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    always_comb begin
        case (addr_e'(bus_addr))
            ADDR_DIR: rd_val = regs_q.dir;
            ADDR_VAL: rd_val = regs_q.val;
            ADDR_ODC: rd_val = regs_q.odc;
            default:  rd_val = (regs_q.dir & regs_q.val) | (~regs_q.dir & pad_sync);
        endcase
        bus_rdata = bus_rd ? {{RSV_W{1'b0}}, rd_val} : '0;
    end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk
    import gpio6_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hw_stby,
    input logic             sw_stby,
    input logic             bus_rd,
    input logic [REG_W-1:0] bus_rdata,
    input logic [PIN_W-1:0] pad_out,
    input logic [PIN_W-1:0] pad_oe,
    input port_regs_t       regs_q
);
    a_r7_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~regs_q.dir) == '0);

    a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & regs_q.odc & pad_out) == '0);

    a_r8_stby_release: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> pad_oe == '0);

    a_r8_stby_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> regs_q == '0);

    a_r9_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(regs_q));

    a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[REG_W-1:PIN_W] == '0);
endmodule

bind gpio6_port gpio6_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .regs_q    (regs_q)
);

// File: tb/tb_gpio6_port.sv
`timescale 1ns/1ps
module tb_gpio6_port;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    gpio6_port dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference model
    int m_dir = 0, m_val = 0, m_odc = 0;
    byte unsigned pad_hist[$] = '{8'd0, 8'd0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_val = 0; m_odc = 0;
            pad_hist = '{8'd0, 8'd0};
        end else begin
            if (!(sw_stby && !hw_stby)) begin
                pad_hist.push_back(byte'(pad_in));
                void'(pad_hist.pop_front());
            end
            if (hw_stby) begin
                m_dir = 0; m_val = 0; m_odc = 0;
            end else if (!sw_stby && bus_wr) begin
                if (bus_addr == 0) m_dir = bus_wdata & 8'h3F;
                if (bus_addr == 1) m_val = bus_wdata & 8'h3F;
                if (bus_addr == 2) m_odc = bus_wdata & 8'h3F;
            end
        end
    end

    function automatic int exp_rdata();
        int s;
        s = pad_hist[0];
        if (!bus_rd) return 0;
        case (bus_addr)
            2'd0: return m_dir;
            2'd1: return m_val;
            2'd2: return m_odc;
            default: return ((m_dir & m_val) | (~m_dir & s)) & 8'h3F;
        endcase
    endfunction

    function automatic int exp_oe();
        int r = 0;
        if (hw_stby) return 0;
        for (int i = 0; i < 6; i++)
            if (m_dir[i] && (!m_odc[i] || !m_val[i])) r |= (1 << i);
        return r;
    endfunction

    function automatic int exp_out();
        return m_val & ~m_odc & 8'h3F;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 R2 R10 rdata", int'(bus_rdata), exp_rdata());
            check("R5 R6 R7 R8 pad_oe", int'(pad_oe), exp_oe());
            check("R5 R6 pad_out", int'(pad_out), exp_out());
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #4;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #4;
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, int exp);
        @(posedge clk); #4;
        bus_addr = a;
        #2;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        #4;
        check("R1 oe in reset", int'(pad_oe), 0);
        rst_n = 1'b1;
        rd_check("R1 dir", 2'd0, 0);
        rd_check("R1 val", 2'd1, 0);
        rd_check("R1 odc", 2'd2, 0);
        check("R1 oe", int'(pad_oe), 0);

        // R2 storage and reserved bits, R5 push-pull
        wr(2'd0, 8'hFF);
        rd_check("R2 dir reserved", 2'd0, 8'h3F);
        wr(2'd1, 8'hEA);
        rd_check("R2 val", 2'd1, 8'h2A);
        check("R5 oe", int'(pad_oe), 8'h3F);
        check("R5 out", int'(pad_out), 8'h2A);

        // R6 open-drain on low nibble
        wr(2'd2, 8'h0F);
        rd_check("R2 odc", 2'd2, 8'h0F);
        check("R6 oe", int'(pad_oe), 8'h35);
        check("R6 out", int'(pad_out), 8'h20);

        rd_check("R4 all outputs", 2'd3, 8'h2A);

        // R4 synchroniser delay, R7 inputs undriven
        wr(2'd0, 8'h07);
        check("R7 oe", int'(pad_oe), 8'h05);
        rd_check("R4 before pad change", 2'd3, 8'h02);
        pad_in = 6'h15;
        @(posedge clk); #6;
        check("R4 one edge", int'(bus_rdata), 8'h02);
        @(posedge clk); #6;
        check("R4 two edges", int'(bus_rdata), 8'h12);

        // R3 writes to pin state ignored
        wr(2'd3, 8'hFF);
        rd_check("R3 dir", 2'd0, 8'h07);
        rd_check("R3 val", 2'd1, 8'h2A);
        rd_check("R3 odc", 2'd2, 8'h0F);

        // R9 software standby
        @(posedge clk); #4;
        sw_stby = 1'b1;
        wr(2'd2, 8'h00);
        pad_in = 6'h2A;
        idle(3);
        rd_check("R9 odc held", 2'd2, 8'h0F);
        rd_check("R9 pin held", 2'd3, 8'h12);
        @(posedge clk); #4;
        sw_stby = 1'b0;
        idle(2);
        rd_check("R9 pin after wake", 2'd3, 8'h2A);

        // R8 hardware standby
        @(posedge clk); #4;
        hw_stby = 1'b1;
        #1;
        check("R8 oe released", int'(pad_oe), 0);
        wr(2'd0, 8'h3F);
        pad_in = 6'h11;
        idle(3);
        @(posedge clk); #4;
        hw_stby = 1'b0;
        rd_check("R8 dir cleared", 2'd0, 0);
        rd_check("R8 odc cleared", 2'd2, 0);
        rd_check("R8 pin follows pads", 2'd3, 8'h11);

        // R10 idle read
        wr(2'd1, 8'h3F);
        @(posedge clk); #4;
        bus_rd = 1'b0; bus_addr = 2'd1;
        #2;
        check("R10 idle rdata", int'(bus_rdata), 0);
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule